// File: doc/BRIEF.md
# TDM Transmit Slot Multiplexer

This block puts up to four on-chip monitoring words (voltage sense, current sense, supply voltage and temperature) onto a serial TDM data line that other devices on the same board also drive. Each source has an enable and a slot number. At the frame sync the block latches a shadow copy of every source word. It then counts bit clocks from the frame start, after a programmable offset, and drives the word of whichever enabled source owns the current 32-bit slot. The word goes out MSB first in either 16 or 24 bits.

When no source owns a bit time, the line is either driven low or released to high impedance, as the fill mode selects. A keeper control lets one device hold the last driven level on a released line. A short-LSB option releases the last bit of each word halfway through its bit period, so it does not fight the MSB that a neighbour drives in the next slot. The launch edge of the bit clock can be set to rising or falling. The bit clock and the frame sync are sampled by a faster core clock, so each bit period must last several core clock cycles.

The controller has five states:
- `ST_WAIT`: after reset, until the first frame start.
- `ST_FILL`: an unused bit time.
- `ST_DRIVE`: a data bit driven for the whole bit period.
- `ST_HALF`: the last bit of a word with short-LSB enabled, during its first half.
- `ST_REL`: the line has been released after such a half bit.

Transitions:
- Every launch edge after the first frame start decodes the new bit position. It moves to `ST_DRIVE`, `ST_HALF` or `ST_FILL`, from any state except `ST_WAIT`.
- `ST_WAIT` leaves only on a launch edge that carries a new frame sync.
- `ST_HALF` moves to `ST_REL` on the opposite bit clock edge.

Top module: `tdm_tx_mux`

## Requirements
- R1: After reset, and until a launch edge samples frame sync high after it was low, `sdout_oe` is 0 and `sdout` is 0 while `keeper_en` is 0.
- R2: Bit position 0 is the launch edge that first sees `fsync` high. An enabled source with slot number S drives its word MSB first, starting at bit position `slot_ofs + 32*S`.
- R3: With `word_long`=0 the slot carries the 16 most significant bits of the 24-bit sample, and its remaining bit times are unused. With `word_long`=1 it carries all 24 bits.
- R4: A source whose `src_en` bit is 0 never drives its slot. That slot is filled as an unused bit time.
- R5: In an unused bit time, `fill_hiz`=0 gives `sdout_oe`=1 and `sdout`=0. `fill_hiz`=1 gives `sdout_oe`=0.
- R6: With `keeper_en`=1, whenever `sdout_oe`=0 the output `keep_hold` is 1 and `sdout` equals the last level driven. With `keeper_en`=0, `keep_hold` is 0 and `sdout` is 0 while released.
- R7: With `lsb_half`=1 the last word bit of a slot is driven only until the opposite bit clock edge, after which `sdout_oe` is 0. With `lsb_half`=0 that bit is driven for the whole period.
- R8: `tx_falling`=0 launches data on rising `bclk` edges; `tx_falling`=1 launches data on falling edges. Outputs change only after a launch edge or, for R7, after an opposite edge.
- R9: Sample words are captured at frame start. A change of `samples` later in a frame appears only in the next frame.
- R10: If two enabled sources share a slot, the lower-indexed source is transmitted, and `collision` becomes 1 at the next frame start and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that samples the bit clock and frame sync |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock, synchronous to `clk` |
| fsync | input | 1 | Frame sync, sampled on launch edges |
| src_en | input | 4 | Per-source enable, bit i for source i |
| src_slot | input | 20 | Per-source slot number, 5 bits per source, source i at [5i+4:5i] |
| samples | input | 96 | Per-source 24-bit words, source i at [24i+23:24i] |
| word_long | input | 1 | 0: 16-bit words, 1: 24-bit words |
| fill_hiz | input | 1 | 0: unused bits driven low, 1: unused bits released |
| keeper_en | input | 1 | Hold last driven level while released |
| lsb_half | input | 1 | Drive the last word bit for half a bit period only |
| tx_falling | input | 1 | 0: launch on rising `bclk`, 1: launch on falling `bclk` |
| slot_ofs | input | 5 | Bit clocks between frame start and slot 0 |
| sdout | output | 1 | Serial data |
| sdout_oe | output | 1 | Output enable for `sdout` |
| keep_hold | output | 1 | Keeper control, active while released with the keeper on |
| collision | output | 1 | Sticky flag for two enabled sources in one slot |

## Verification
A wrong state or position counter shows at the ports within one bit period. A data bit appears in the wrong bit time, or the output enable is raised or dropped in the wrong half of a bit. A stale shadow register shows up one whole frame late, as the previous word in the slot. A wrong keeper level is visible on the first released half-bit after a driven bit. A collision flag that fails to stick, or that is set without cause, is seen on the first frame after the configuration that should or should not trigger it.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_FILL  = 3'd1,
        ST_DRIVE = 3'd2,
        ST_HALF  = 3'd3,
        ST_REL   = 3'd4
    } tx_state_t;

endpackage

// File: rtl/tdm_edge_det.sv
module tdm_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic tx_falling,
    output logic launch_o,
    output logic other_o,
    output logic frame_start_o
);

    logic bclk_q;
    logic fs_prev_q;
    logic rise;
    logic fall;

    assign rise = bclk & ~bclk_q;
    assign fall = ~bclk & bclk_q;
    assign launch_o = tx_falling ? fall : rise;
    assign other_o  = tx_falling ? rise : fall;
    assign frame_start_o = launch_o & fsync & ~fs_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q    <= 1'b0;
            fs_prev_q <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (launch_o) begin
                fs_prev_q <= fsync;
            end
        end
    end

endmodule

// File: rtl/tdm_shadow.sv
module tdm_shadow #(
    parameter int NSRC   = 4,
    parameter int DATA_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [NSRC*DATA_W-1:0] samples_i,
    output logic [NSRC*DATA_W-1:0] words_o
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic [DATA_W-1:0] held_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q <= '0;
            end else if (load) begin
                held_q <= samples_i[g*DATA_W +: DATA_W];
            end
        end

        assign words_o[g*DATA_W +: DATA_W] = load ? samples_i[g*DATA_W +: DATA_W] : held_q;
    end

endmodule

// File: rtl/tdm_slot_sel.sv
module tdm_slot_sel #(
    parameter int NSRC   = 4,
    parameter int SLOT_W = 5,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]        en_i,
    input  logic [NSRC*SLOT_W-1:0] slots_i,
    input  logic [SLOT_W-1:0]      slot_i,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       idx_o,
    output logic                   dup_o
);

    logic [NSRC-1:0] match;

    for (genvar g = 0; g < NSRC; g++) begin : g_match
        assign match[g] = en_i[g] && (slots_i[g*SLOT_W +: SLOT_W] == slot_i);
    end

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    always_comb begin
        dup_o = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            for (int j = i + 1; j < NSRC; j++) begin
                if (en_i[i] && en_i[j] &&
                    (slots_i[i*SLOT_W +: SLOT_W] == slots_i[j*SLOT_W +: SLOT_W])) begin
                    dup_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux
    import tdm_pkg::*;
#(
    parameter int NSRC      = 4,
    parameter int LONG_W    = 24,
    parameter int SHORT_W   = 16,
    parameter int SLOT_BITS = 32,
    parameter int SLOT_W    = 5,
    parameter int OFS_W     = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bclk,
    input  logic                     fsync,
    input  logic [NSRC-1:0]          src_en,
    input  logic [NSRC*SLOT_W-1:0]   src_slot,
    input  logic [NSRC*LONG_W-1:0]   samples,
    input  logic                     word_long,
    input  logic                     fill_hiz,
    input  logic                     keeper_en,
    input  logic                     lsb_half,
    input  logic                     tx_falling,
    input  logic [OFS_W-1:0]         slot_ofs,
    output logic                     sdout,
    output logic                     sdout_oe,
    output logic                     keep_hold,
    output logic                     collision
);

    localparam int SB_LOG = $clog2(SLOT_BITS);
    localparam int CNT_W  = SLOT_W + SB_LOG;
    localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

    logic launch_edge;
    logic other_edge;
    logic frame_start;

    tdm_edge_det u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk         (bclk),
        .fsync        (fsync),
        .tx_falling   (tx_falling),
        .launch_o     (launch_edge),
        .other_o      (other_edge),
        .frame_start_o(frame_start)
    );

    logic [NSRC*LONG_W-1:0] words;

    tdm_shadow #(.NSRC(NSRC), .DATA_W(LONG_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_start),
        .samples_i(samples),
        .words_o  (words)
    );

    // Bit position decode for the bit that starts at this launch edge
    logic [CNT_W-1:0]  pos_q;
    logic [CNT_W-1:0]  pos_cur;
    logic [CNT_W-1:0]  rel;
    logic [CNT_W-1:0]  ofs_ext;
    logic [SLOT_W-1:0] cur_slot;
    logic [SB_LOG-1:0] bidx;
    logic              in_win;

    assign ofs_ext  = CNT_W'(slot_ofs);
    assign pos_cur  = frame_start ? '0 : ((pos_q == POS_MAX) ? POS_MAX : pos_q + 1'b1);
    assign in_win   = (pos_cur >= ofs_ext);
    assign rel      = pos_cur - ofs_ext;
    assign cur_slot = rel[CNT_W-1:SB_LOG];
    assign bidx     = rel[SB_LOG-1:0];

    logic             hit;
    logic [IDX_W-1:0] win_idx;
    logic             dup;

    tdm_slot_sel #(.NSRC(NSRC), .SLOT_W(SLOT_W)) u_sel (
        .en_i   (src_en),
        .slots_i(src_slot),
        .slot_i (cur_slot),
        .hit_o  (hit),
        .idx_o  (win_idx),
        .dup_o  (dup)
    );

    logic [LONG_W-1:0] sel_word;
    logic              data_bit;
    logic              in_word;
    logic              last_bit;
    int                wlen_i;

    assign sel_word = words[win_idx*LONG_W +: LONG_W];

    always_comb begin
        wlen_i   = word_long ? LONG_W : SHORT_W;
        in_word  = (int'(bidx) < wlen_i);
        last_bit = (int'(bidx) == wlen_i - 1);
        data_bit = 1'b0;
        for (int k = 0; k < LONG_W; k++) begin
            if (k == LONG_W - 1 - int'(bidx)) begin
                data_bit = sel_word[k];
            end
        end
    end

    // State machine
    tx_state_t state_q;
    tx_state_t state_d;
    tx_state_t dec_state;
    logic      advance;

    always_comb begin
        if (in_win && hit && in_word) begin
            dec_state = (last_bit && lsb_half) ? ST_HALF : ST_DRIVE;
        end else begin
            dec_state = ST_FILL;
        end
    end

    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (frame_start) begin
                    state_d = dec_state;
                    advance = 1'b1;
                end
            end
            ST_HALF: begin
                if (launch_edge) begin
                    state_d = dec_state;
                    advance = 1'b1;
                end else if (other_edge) begin
                    state_d = ST_REL;
                end
            end
            ST_FILL, ST_DRIVE, ST_REL: begin
                if (launch_edge) begin
                    state_d = dec_state;
                    advance = 1'b1;
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    logic bit_q;
    logic last_q;
    logic coll_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            pos_q   <= '0;
            bit_q   <= 1'b0;
            last_q  <= 1'b0;
            coll_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (advance) begin
                pos_q <= pos_cur;
                bit_q <= data_bit;
            end
            if (sdout_oe) begin
                last_q <= sdout;
            end
            if (frame_start && dup) begin
                coll_q <= 1'b1;
            end
        end
    end

    // Output process
    always_comb begin
        sdout    = 1'b0;
        sdout_oe = 1'b0;
        unique case (state_q)
            ST_DRIVE, ST_HALF: begin
                sdout_oe = 1'b1;
                sdout    = bit_q;
            end
            ST_FILL: begin
                sdout_oe = ~fill_hiz;
                sdout    = fill_hiz ? (keeper_en & last_q) : 1'b0;
            end
            ST_WAIT, ST_REL: begin
                sdout_oe = 1'b0;
                sdout    = keeper_en & last_q;
            end
            default: begin
                sdout_oe = 1'b0;
                sdout    = 1'b0;
            end
        endcase
    end

    assign keep_hold = keeper_en & ~sdout_oe;
    assign collision = coll_q;

    assert_wait_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !sdout_oe);

    assert_half_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALF && other_edge && !launch_edge) |=> !sdout_oe);

    assert_keeper_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (keeper_en && $past(keeper_en) && !sdout_oe && $past(sdout_oe)) |-> (sdout == $past(sdout)));

    assert_collision_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> collision);

    assert_quiet_between_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch_edge && !other_edge) |=> $stable(state_q));

endmodule

// File: tb/sim_tdm_tx_mux.sv
module sim_tdm_tx_mux;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 4;
    localparam int DW    = 24;
    localparam int SW    = 5;
    localparam int FRAME = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0;
    logic fsync = 1'b0;
    logic [NSRC-1:0]    src_en = '0;
    logic [NSRC*SW-1:0] src_slot = '0;
    logic [NSRC*DW-1:0] samples = '0;
    logic word_long = 1'b0;
    logic fill_hiz = 1'b0;
    logic keeper_en = 1'b0;
    logic lsb_half = 1'b0;
    logic tx_falling = 1'b0;
    logic [4:0] slot_ofs = '0;
    logic sdout, sdout_oe, keep_hold, collision;

    int n_checks = 0;
    int n_fails = 0;
    logic model_last = 1'b0;

    logic c_oe1 [FRAME];
    logic c_d1  [FRAME];
    logic c_k1  [FRAME];
    logic c_oe2 [FRAME];
    logic c_d2  [FRAME];
    logic c_k2  [FRAME];

    tdm_tx_mux u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .src_en(src_en), .src_slot(src_slot), .samples(samples),
        .word_long(word_long), .fill_hiz(fill_hiz), .keeper_en(keeper_en),
        .lsb_half(lsb_half), .tx_falling(tx_falling), .slot_ofs(slot_ofs),
        .sdout(sdout), .sdout_oe(sdout_oe), .keep_hold(keep_hold), .collision(collision)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_up();
    end

    task automatic check1(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic set_src(input int i, input bit en, input int slot, input logic [DW-1:0] w);
        src_en[i] = en;
        src_slot[i*SW +: SW] = slot[4:0];
        samples[i*DW +: DW] = w;
    endtask

    task automatic step_bit(input int p, input bit fs);
        logic lv;
        lv = tx_falling ? 1'b0 : 1'b1;
        @(posedge clk); #1;
        bclk = lv;
        fsync = fs;
        @(posedge clk); @(posedge clk); @(negedge clk);
        c_oe1[p] = sdout_oe; c_d1[p] = sdout; c_k1[p] = keep_hold;
        @(posedge clk); @(posedge clk); #1;
        bclk = ~lv;
        @(posedge clk); @(posedge clk); @(negedge clk);
        c_oe2[p] = sdout_oe; c_d2[p] = sdout; c_k2[p] = keep_hold;
    endtask

    task automatic check_frame(input string tag, input logic [NSRC*DW-1:0] s);
        int errs = 0;
        string first = "";
        for (int p = 0; p < FRAME; p++) begin
            logic e_oe1, e_d1, e_oe2, e_d2;
            int rel, slot, b, win, wl;
            bit found = 0;
            wl = word_long ? 24 : 16;
            rel = p - int'(slot_ofs);
            slot = 0; b = 0; win = 0;
            if (rel >= 0) begin
                slot = rel / 32;
                b = rel % 32;
                for (int i = 0; i < NSRC; i++) begin
                    if (!found && src_en[i] && int'(src_slot[i*SW +: SW]) == slot) begin
                        found = 1;
                        win = i;
                    end
                end
            end
            if (found && b < wl) begin
                e_oe1 = 1'b1;
                e_d1 = s[win*DW + (DW - 1 - b)];
                model_last = e_d1;
                if (b == wl - 1 && lsb_half) begin
                    e_oe2 = 1'b0;
                    e_d2 = keeper_en ? e_d1 : 1'b0;
                end else begin
                    e_oe2 = 1'b1;
                    e_d2 = e_d1;
                end
            end else if (!fill_hiz) begin
                e_oe1 = 1'b1; e_d1 = 1'b0;
                e_oe2 = 1'b1; e_d2 = 1'b0;
                model_last = 1'b0;
            end else begin
                e_oe1 = 1'b0; e_d1 = keeper_en ? model_last : 1'b0;
                e_oe2 = 1'b0; e_d2 = e_d1;
            end
            if (c_oe1[p] !== e_oe1 || c_d1[p] !== e_d1 || c_oe2[p] !== e_oe2 ||
                c_d2[p] !== e_d2 || c_k1[p] !== (keeper_en & ~e_oe1) ||
                c_k2[p] !== (keeper_en & ~e_oe2)) begin
                if (errs == 0) begin
                    first = $sformatf("bit %0d actual oe/d/k=%0b%0b%0b,%0b%0b%0b expected=%0b%0b%0b,%0b%0b%0b",
                        p, c_oe1[p], c_d1[p], c_k1[p], c_oe2[p], c_d2[p], c_k2[p],
                        e_oe1, e_d1, keeper_en & ~e_oe1, e_oe2, e_d2, keeper_en & ~e_oe2);
                end
                errs++;
            end
        end
        n_checks++;
        if (errs != 0) begin
            n_fails++;
            $display("FAIL %s: %0d bad bits, first %s", tag, errs, first);
        end
    endtask

    task automatic run_frame(input string tag, input int chg_bit, input logic [NSRC*DW-1:0] new_s);
        logic [NSRC*DW-1:0] s;
        @(posedge clk); #1;
        bclk = tx_falling ? 1'b1 : 1'b0;
        repeat (4) @(posedge clk);
        s = samples;
        for (int p = 0; p < FRAME; p++) begin
            if (p == chg_bit) samples = new_s;
            step_bit(p, p == 0);
        end
        check_frame(tag, s);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check1("R1 reset oe", sdout_oe, 1'b0);
        check1("R1 reset sdout", sdout, 1'b0);
        check1("R1 reset keep_hold", keep_hold, 1'b0);
        check1("R10 reset collision", collision, 1'b0);
        set_src(0, 1, 0, 24'hC3A55A);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1 bclk = 1'b1;
            repeat (3) @(posedge clk);
            #1 bclk = 1'b0;
            repeat (2) @(posedge clk);
            @(negedge clk);
            check1("R1 no frame sync oe", sdout_oe, 1'b0);
        end
    endtask

    task automatic t_basic();
        set_src(0, 1, 0, 24'hC3A55A);
        set_src(1, 1, 1, 24'h5AF00F);
        set_src(2, 0, 2, 24'h123456);
        set_src(3, 0, 3, 24'h89ABCD);
        word_long = 0; fill_hiz = 0; keeper_en = 0; lsb_half = 0; slot_ofs = 0;
        run_frame("R2 R3 R5 basic 16-bit zero fill", -1, samples);
        check1("R10 no collision", collision, 1'b0);
    endtask

    task automatic t_len24();
        word_long = 1;
        set_src(0, 1, 0, 24'h9C3E71);
        run_frame("R3 24-bit words", -1, samples);
        word_long = 0;
    endtask

    task automatic t_disabled();
        set_src(0, 0, 0, 24'hFFFFFF);
        set_src(2, 1, 1, 24'hB4D2E1);
        set_src(1, 0, 1, 24'h000000);
        fill_hiz = 1;
        run_frame("R4 R5 disabled source and hi-z fill", -1, samples);
    endtask

    task automatic t_offset();
        set_src(0, 1, 0, 24'hA11FE5);
        set_src(1, 1, 1, 24'h7E81C3);
        set_src(2, 0, 2, 24'h0);
        fill_hiz = 0;
        slot_ofs = 5'd3;
        run_frame("R2 slot offset 3", -1, samples);
        slot_ofs = 0;
    endtask

    task automatic t_keeper();
        fill_hiz = 1;
        keeper_en = 1;
        set_src(0, 1, 0, 24'hFFFF00);
        set_src(1, 1, 1, 24'h0001FF);
        run_frame("R6 keeper holds last level", -1, samples);
        keeper_en = 0;
        run_frame("R6 keeper off released low", -1, samples);
    endtask

    task automatic t_lsb();
        fill_hiz = 1;
        lsb_half = 1;
        keeper_en = 0;
        set_src(0, 1, 0, 24'h8001FF);
        set_src(1, 1, 1, 24'h3C5B01);
        run_frame("R7 short LSB", -1, samples);
        keeper_en = 1;
        word_long = 1;
        run_frame("R7 short LSB with keeper 24-bit", -1, samples);
        keeper_en = 0; word_long = 0; lsb_half = 0;
    endtask

    task automatic t_falling();
        tx_falling = 1;
        fill_hiz = 0;
        set_src(0, 1, 1, 24'hD6A3B9);
        set_src(1, 1, 0, 24'h2B9C47);
        run_frame("R8 falling launch edge", -1, samples);
        tx_falling = 0;
        run_frame("R8 rising launch edge again", -1, samples);
    endtask

    task automatic t_shadow();
        logic [NSRC*DW-1:0] nw;
        set_src(0, 1, 0, 24'h111111);
        set_src(1, 1, 1, 24'h222222);
        nw = samples;
        nw[0 +: DW] = 24'hEEEEEE;
        nw[DW +: DW] = 24'hDDDDDD;
        run_frame("R9 mid-frame update ignored", 5, nw);
        run_frame("R9 update seen next frame", -1, samples);
    endtask

    task automatic t_collision();
        set_src(0, 1, 0, 24'hF0F0F0);
        set_src(1, 1, 1, 24'hA5A5A5);
        set_src(3, 1, 1, 24'h5A5A5A);
        run_frame("R10 lower index wins", -1, samples);
        check1("R10 collision set", collision, 1'b1);
        set_src(3, 0, 1, 24'h5A5A5A);
        run_frame("R10 frame after reconfig", -1, samples);
        check1("R10 collision sticky", collision, 1'b1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_len24();
        t_disabled();
        t_offset();
        t_keeper();
        t_lsb();
        t_falling();
        t_shadow();
        t_collision();
        finish_up();
    end

endmodule